// File: doc/BRIEF.md
# Double-to-Single Precision Narrowing Converter

This unit takes a 64-bit IEEE 754 double operand and produces the nearest 32-bit IEEE 754 single under one of four rounding modes. It moves the exponent from the wide bias to the narrow bias and keeps the upper 23 fraction bits. The dropped fraction bits decide the rounding. Results outside the single range are saturated, and results too small for it are flushed. Zeros and infinities keep their sign. Quiet NaNs keep their top payload bits. A signaling NaN is replaced by a fixed default NaN. A denormal double is not converted: it is refused with an "unfinished" trap type, so that a slower handler can deal with it.

A conversion starts with a one-cycle `start` strobe while the unit is idle. A small state machine walks through four states:
- IDLE: waits for `start`, capturing the operand and rounding mode (IDLE→DECODE on `start`).
- DECODE: classifies the operand and registers the rounding outcome (DECODE→ROUND, unconditional).
- ROUND: packs the final result, exception vector and trap type into the output registers (ROUND→DONE, unconditional).
- DONE: raises `done` for one cycle (DONE→IDLE, unconditional).

The outputs hold their values until the next conversion writes them.

Top module: `narrow_top`

## Requirements
- R1: `start` is taken only in IDLE. `done` is a one-cycle pulse in the third cycle after the cycle in which `start` was sampled. A `start` seen during a conversion is ignored and does not alter the result in progress.
- R2: A normal operand whose rebiased exponent (double exponent minus 896) lies in 1..254 gives sign unchanged, that exponent, and the top 23 fraction bits. When no nonzero bits are dropped, the exception vector is 0.
- R3: `rmode` selects the rounding: 0 is to nearest with ties to even, 1 is toward zero, 2 is toward +infinity, 3 is toward −infinity. Nearest uses the guard bit, the round bit and the OR of all lower bits.
- R4: Exception bit 0 (inexact) is set whenever rounding drops nonzero bits, and also on every overflow or underflow.
- R5: When rounding up carries out of the 23-bit fraction, the fraction becomes zero and the exponent rises by one.
- R6: When the exponent after rounding is 255 or more, exception bit 3 (overflow) and bit 0 are set. The result is infinity of the operand's sign in mode 0, and in the mode rounding away from zero for that sign. Otherwise it is the largest finite single of that sign (exponent 254, fraction all ones).
- R7: When the rebiased exponent before rounding is 0 or less, the result is a zero with the operand's sign, and exception bit 2 (underflow) and bit 0 are set.
- R8: A quiet NaN (exponent all ones, fraction MSB 1) becomes sign, exponent 0xFF, fraction MSB 1, and then double fraction bits 50..29. No exception bit is set.
- R9: A signaling NaN (exponent all ones, fraction MSB 0, fraction nonzero) gives 0x7FFF0000 with exception bit 4 (invalid) set, whatever its sign.
- R10: Zeros and infinities convert to the same value in single form, with their sign and no exception bit.
- R11: A denormal operand (exponent 0, fraction nonzero) gives trap type 2, result 0 and exception vector 0.
- R12: Trap type is 1 when any of exception bits 4, 3 or 2 is set, 2 under R11, and 0 otherwise. Exception bit 1 (divide by zero) is never set.
- R13: After reset, `result`, `flags` and `ttype` are zero and `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion (taken only in IDLE) |
| op_in | input | 64 | Double-precision operand |
| rmode | input | 2 | Rounding mode: 0 nearest, 1 zero, 2 +inf, 3 −inf |
| result | output | 32 | Single-precision result |
| flags | output | 5 | Exception vector: bit4 invalid, bit3 overflow, bit2 underflow, bit1 divide-by-zero, bit0 inexact |
| ttype | output | 3 | Trap type: 0 none, 1 IEEE exception, 2 unfinished |
| done | output | 1 | One-cycle completion pulse |

## Verification
A corrupted state register or a missed transition shows at the ports within a few cycles. The symptom is either a `done` pulse that arrives at any cycle other than the third after `start`, or a pulse that repeats or never comes. The watchdog and the latency check catch either case on the very first conversion. A wrong class or a wrong rounding term latched in DECODE appears in the same `done` cycle as a result, exception vector or trap type that disagrees with the scoreboard entry. The flag-to-result pairing checks also catch it as soon as the output is valid. A stray load of the output registers outside ROUND breaks the hold check on the next edge.

// File: rtl/narrow_pkg.sv
package narrow_pkg;

    // Operand classes found by the classifier
    typedef enum logic [2:0] {
        CL_ZERO = 3'd0,
        CL_SUB  = 3'd1,
        CL_NORM = 3'd2,
        CL_INF  = 3'd3,
        CL_QNAN = 3'd4,
        CL_SNAN = 3'd5
    } opclass_t;

    // Rounding-mode encoding (visible on the rmode port)
    typedef enum logic [1:0] {
        RND_NEAR = 2'd0,
        RND_ZERO = 2'd1,
        RND_POS  = 2'd2,
        RND_NEG  = 2'd3
    } rnd_t;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_ROUND  = 2'd2,
        ST_DONE   = 2'd3
    } fsm_t;

    // Exception vector bit positions
    localparam int FLG_NX = 0;
    localparam int FLG_DZ = 1;
    localparam int FLG_UF = 2;
    localparam int FLG_OF = 3;
    localparam int FLG_NV = 4;
    localparam int FLG_W  = 5;

    // Trap type codes
    localparam int TT_W = 3;
    localparam logic [TT_W-1:0] TT_NONE  = 3'd0;
    localparam logic [TT_W-1:0] TT_IEEE  = 3'd1;
    localparam logic [TT_W-1:0] TT_UNFIN = 3'd2;

endpackage

// File: rtl/narrow_classify.sv
module narrow_classify
    import narrow_pkg::*;
#(
    parameter int EWI = 11,
    parameter int FWI = 52,
    localparam int IW = EWI + FWI + 1
) (
    input  logic [IW-1:0] op,
    output opclass_t      cls
);
    logic [EWI-1:0] e_in;
    logic [FWI-1:0] f_in;

    always_comb begin
        e_in = op[IW-2:FWI];
        f_in = op[FWI-1:0];
        if (e_in == '0) begin
            cls = (f_in == '0) ? CL_ZERO : CL_SUB;
        end else if (e_in == '1) begin
            if (f_in == '0)
                cls = CL_INF;
            else if (f_in[FWI-1])
                cls = CL_QNAN;
            else
                cls = CL_SNAN;
        end else begin
            cls = CL_NORM;
        end
    end
endmodule

// File: rtl/narrow_round.sv
module narrow_round
    import narrow_pkg::*;
#(
    parameter int EWI = 11,
    parameter int FWI = 52,
    parameter int EWO = 8,
    parameter int FWO = 23,
    localparam int IW = EWI + FWI + 1
) (
    input  logic [IW-1:0]  op,
    input  rnd_t           rm,
    output logic [EWO-1:0] exp_out,
    output logic [FWO-1:0] frac_out,
    output logic           tiny,
    output logic           ovf,
    output logic           inexact
);
    localparam int EXW       = EWI + 2;
    localparam int DROP      = FWI - FWO;
    localparam int BIAS_DIFF = (2 ** (EWI - 1) - 1) - (2 ** (EWO - 1) - 1);
    localparam int EXP_TOP   = 2 ** EWO - 1;

    logic           sgn;
    logic [EWI-1:0] e_in;
    logic [FWI-1:0] f_in;
    logic [FWO-1:0] kept;
    logic           g_bit, r_bit, s_bit, up, carry;
    logic [FWO:0]   sum;
    logic [EXW-1:0] exp_reb, exp_fin;

    always_comb begin
        sgn   = op[IW-1];
        e_in  = op[IW-2:FWI];
        f_in  = op[FWI-1:0];
        kept  = f_in[FWI-1 -: FWO];
        g_bit = f_in[DROP-1];
        r_bit = f_in[DROP-2];
        s_bit = |f_in[DROP-3:0];
        inexact = g_bit | r_bit | s_bit;

        unique case (rm)
            RND_NEAR: up = g_bit & (r_bit | s_bit | kept[0]);
            RND_ZERO: up = 1'b0;
            RND_POS:  up = ~sgn & inexact;
            RND_NEG:  up = sgn & inexact;
            default:  up = 1'b0;
        endcase

        sum   = {1'b0, kept} + {{FWO{1'b0}}, up};
        carry = sum[FWO];

        exp_reb = EXW'(e_in) - EXW'(BIAS_DIFF);
        exp_fin = exp_reb + {{(EXW-1){1'b0}}, carry};

        tiny     = exp_reb[EXW-1] | (exp_reb == '0);
        ovf      = ~exp_fin[EXW-1] & (exp_fin >= EXW'(EXP_TOP));
        exp_out  = exp_fin[EWO-1:0];
        frac_out = sum[FWO-1:0];
    end
endmodule

// File: rtl/narrow_pack.sv
module narrow_pack
    import narrow_pkg::*;
#(
    parameter int EWO = 8,
    parameter int FWO = 23,
    localparam int RW = EWO + FWO + 1,
    parameter logic [RW-1:0] DFLT_NAN = 32'h7fff0000
) (
    input  opclass_t         cls,
    input  logic             sgn,
    input  rnd_t             rm,
    input  logic [FWO-2:0]   payload,
    input  logic [EWO-1:0]   exp_in,
    input  logic [FWO-1:0]   frac_in,
    input  logic             tiny,
    input  logic             ovf,
    input  logic             inexact,
    output logic [RW-1:0]    res,
    output logic [FLG_W-1:0] flg,
    output logic [TT_W-1:0]  tt
);
    logic          to_inf;
    logic [RW-1:0] inf_val, max_val, zero_val;

    always_comb begin
        to_inf   = (rm == RND_NEAR) | ((rm == RND_POS) & ~sgn) | ((rm == RND_NEG) & sgn);
        inf_val  = {sgn, {EWO{1'b1}}, {FWO{1'b0}}};
        max_val  = {sgn, {(EWO-1){1'b1}}, 1'b0, {FWO{1'b1}}};
        zero_val = {sgn, {(RW-1){1'b0}}};
        res = '0;
        flg = '0;
        tt  = TT_NONE;

        unique case (cls)
            CL_ZERO: res = zero_val;
            CL_SUB: begin
                res = '0;
                tt  = TT_UNFIN;
            end
            CL_INF:  res = inf_val;
            CL_QNAN: res = {sgn, {EWO{1'b1}}, 1'b1, payload};
            CL_SNAN: begin
                res         = DFLT_NAN;
                flg[FLG_NV] = 1'b1;
            end
            CL_NORM: begin
                if (tiny) begin
                    res         = zero_val;
                    flg[FLG_UF] = 1'b1;
                    flg[FLG_NX] = 1'b1;
                end else if (ovf) begin
                    res         = to_inf ? inf_val : max_val;
                    flg[FLG_OF] = 1'b1;
                    flg[FLG_NX] = 1'b1;
                end else begin
                    res         = {sgn, exp_in, frac_in};
                    flg[FLG_NX] = inexact;
                end
            end
            default: res = '0;
        endcase

        if (flg[FLG_NV] | flg[FLG_OF] | flg[FLG_UF])
            tt = TT_IEEE;
    end
endmodule

// File: rtl/narrow_top.sv
module narrow_top
    import narrow_pkg::*;
#(
    parameter int EWI = 11,
    parameter int FWI = 52,
    parameter int EWO = 8,
    parameter int FWO = 23,
    localparam int IW = EWI + FWI + 1,
    localparam int RW = EWO + FWO + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IW-1:0]    op_in,
    input  logic [1:0]       rmode,
    output logic [RW-1:0]    result,
    output logic [FLG_W-1:0] flags,
    output logic [TT_W-1:0]  ttype,
    output logic             done
);
    fsm_t state, nxt;

    // Operand capture
    logic [IW-1:0] op_q;
    rnd_t          rm_q;

    // DECODE-stage registers
    opclass_t       cls_q;
    logic [EWO-1:0] rexp_q;
    logic [FWO-1:0] rfrac_q;
    logic           tiny_q, ovf_q, nx_q;

    // Combinational stage outputs
    opclass_t         cls_c;
    logic [EWO-1:0]   rexp_c;
    logic [FWO-1:0]   rfrac_c;
    logic             tiny_c, ovf_c, nx_c;
    logic [RW-1:0]    res_c;
    logic [FLG_W-1:0] flg_c;
    logic [TT_W-1:0]  tt_c;

    narrow_classify #(.EWI(EWI), .FWI(FWI)) u_class (
        .op  (op_q),
        .cls (cls_c)
    );

    narrow_round #(.EWI(EWI), .FWI(FWI), .EWO(EWO), .FWO(FWO)) u_round (
        .op       (op_q),
        .rm       (rm_q),
        .exp_out  (rexp_c),
        .frac_out (rfrac_c),
        .tiny     (tiny_c),
        .ovf      (ovf_c),
        .inexact  (nx_c)
    );

    narrow_pack #(.EWO(EWO), .FWO(FWO)) u_pack (
        .cls     (cls_q),
        .sgn     (op_q[IW-1]),
        .rm      (rm_q),
        .payload (op_q[FWI-2 -: FWO-1]),
        .exp_in  (rexp_q),
        .frac_in (rfrac_q),
        .tiny    (tiny_q),
        .ovf     (ovf_q),
        .inexact (nx_q),
        .res     (res_c),
        .flg     (flg_c),
        .tt      (tt_c)
    );

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_DECODE;
            ST_DECODE: nxt = ST_ROUND;
            ST_ROUND:  nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            rm_q    <= RND_NEAR;
            cls_q   <= CL_ZERO;
            rexp_q  <= '0;
            rfrac_q <= '0;
            tiny_q  <= 1'b0;
            ovf_q   <= 1'b0;
            nx_q    <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                op_q <= op_in;
                rm_q <= rnd_t'(rmode);
            end
            if (state == ST_DECODE) begin
                cls_q   <= cls_c;
                rexp_q  <= rexp_c;
                rfrac_q <= rfrac_c;
                tiny_q  <= tiny_c;
                ovf_q   <= ovf_c;
                nx_q    <= nx_c;
            end
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            flags  <= '0;
            ttype  <= TT_NONE;
            done   <= 1'b0;
        end else begin
            done <= (nxt == ST_DONE);
            if (state == ST_ROUND) begin
                result <= res_c;
                flags  <= flg_c;
                ttype  <= tt_c;
            end
        end
    end
endmodule

// File: rtl/narrow_chk.sv
module narrow_chk
    import narrow_pkg::*;
#(
    parameter int RW = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [RW-1:0]    result,
    input logic [FLG_W-1:0] flags,
    input logic [TT_W-1:0]  ttype,
    input logic             done
);
    // R1: done lasts one cycle
    a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: done follows the accepted start by three cycles
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(start, 3));

    // R1: outputs change only together with a new done pulse
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(done) |-> ($stable(result) && $stable(flags) && $stable(ttype)));

    // R6: overflow gives inexact and a saturated magnitude
    a_r6_overflow_value: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flags[FLG_OF]) |-> (flags[FLG_NX] &&
            (result[RW-2:0] == 31'h7f800000 || result[RW-2:0] == 31'h7f7fffff)));

    // R7: underflow flushes to a signed zero with inexact
    a_r7_underflow_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flags[FLG_UF]) |-> (flags[FLG_NX] && result[RW-2:0] == '0));

    // R9: invalid comes only with the default NaN
    a_r9_invalid_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flags[FLG_NV]) |-> (result == 32'h7fff0000));

    // R11: unfinished trap carries no flags and a zero result
    a_r11_unfinished_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ttype == TT_UNFIN) |-> (flags == '0 && result == '0));

    // R12: divide-by-zero never set; trap type follows the flags
    a_r12_no_dz: assert property (@(posedge clk) disable iff (!rst_n)
        !flags[FLG_DZ]);

    a_r12_ieee_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (flags[FLG_NV] || flags[FLG_OF] || flags[FLG_UF])) |-> (ttype == TT_IEEE));
endmodule

bind narrow_top narrow_chk #(.RW(32)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .result (result),
    .flags  (flags),
    .ttype  (ttype),
    .done   (done)
);

// File: tb/tb_narrow_top.sv
`timescale 1ns/1ps
module tb_narrow_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] op_in = '0;
    logic [1:0]  rmode = '0;
    logic [31:0] result;
    logic [4:0]  flags;
    logic [2:0]  ttype;
    logic        done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic [4:0]  flg;
        logic [2:0]  tt;
        string       tag;
    } exp_t;

    exp_t sb[$];

    narrow_top dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .op_in  (op_in),
        .rmode  (rmode),
        .result (result),
        .flags  (flags),
        .ttype  (ttype),
        .done   (done)
    );

    always #2.5 clk = ~clk;

    // Monitor: pop and compare on each done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R1 unexpected done: actual result=%h expected no pulse", result);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (result !== e.res || flags !== e.flg || ttype !== e.tt) begin
                    fails++;
                    $display("FAIL %s: actual res=%h flg=%b tt=%0d expected res=%h flg=%b tt=%0d",
                             e.tag, result, flags, ttype, e.res, e.flg, e.tt);
                end
            end
        end
    end

    // Driver: start one conversion, push the expectation, wait for done
    task automatic apply(input logic [63:0] op, input logic [1:0] rm,
                         input logic [31:0] xr, input logic [4:0] xf,
                         input logic [2:0] xt, input string tag,
                         output int lat);
        exp_t e;
        e.res = xr; e.flg = xf; e.tt = xt; e.tag = tag;
        @(negedge clk);
        op_in = op; rmode = rm; start = 1'b1;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic vec(input logic [63:0] op, input logic [1:0] rm,
                       input logic [31:0] xr, input logic [4:0] xf,
                       input logic [2:0] xt, input string tag);
        int lat;
        apply(op, rm, xr, xf, xt, tag, lat);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual still running expected finished");
        finish_run();
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R13: reset state
        checks++;
        if (result !== 32'h0 || flags !== 5'h0 || ttype !== 3'h0 || done !== 1'b0) begin
            fails++;
            $display("FAIL R13 reset: actual res=%h flg=%b tt=%0d done=%b expected 0 0 0 0",
                     result, flags, ttype, done);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: latency of exactly three cycles
        apply(64'h3ff0000000000000, 2'd0, 32'h3f800000, 5'h00, 3'd0, "R2 one", lat);
        checks++;
        if (lat != 3) begin
            fails++;
            $display("FAIL R1 latency: actual %0d expected 3", lat);
        end

        // R2: plain rebias
        vec(64'h40ac024680000000, 2'd0, 32'h45601234, 5'h00, 3'd0, "R2 exact");
        vec(64'hc601579a20000000, 2'd0, 32'hf00abcd1, 5'h00, 3'd0, "R2 negative");
        vec(64'h3810000000000000, 2'd0, 32'h00800000, 5'h00, 3'd0, "R2 smallest normal");

        // R3: rounding modes
        vec(64'h3ff0000010000000, 2'd0, 32'h3f800000, 5'h01, 3'd0, "R3 tie to even");
        vec(64'h3ff0000030000000, 2'd0, 32'h3f800002, 5'h01, 3'd0, "R3 tie odd up");
        vec(64'h3ff0000018000000, 2'd0, 32'h3f800001, 5'h01, 3'd0, "R3 above half");
        vec(64'h3ff0000010000000, 2'd2, 32'h3f800001, 5'h01, 3'd0, "R3 toward plus");
        vec(64'h3ff0000030000000, 2'd1, 32'h3f800001, 5'h01, 3'd0, "R3 toward zero");
        vec(64'hbff0000010000000, 2'd3, 32'hbf800001, 5'h01, 3'd0, "R3 toward minus neg");
        vec(64'hbff0000010000000, 2'd2, 32'hbf800000, 5'h01, 3'd0, "R3 toward plus neg");

        // R4: sticky-only inexact
        vec(64'h3ff0000000000001, 2'd0, 32'h3f800000, 5'h01, 3'd0, "R4 sticky inexact");

        // R5: carry into exponent
        vec(64'h3fffffffffffffff, 2'd0, 32'h40000000, 5'h01, 3'd0, "R5 carry");

        // R6: overflow per mode
        vec(64'h47f0000000000000, 2'd0, 32'h7f800000, 5'h09, 3'd1, "R6 R12 overflow nearest");
        vec(64'h47efffffffffffff, 2'd0, 32'h7f800000, 5'h09, 3'd1, "R6 R5 carry overflow");
        vec(64'h47efffffffffffff, 2'd1, 32'h7f7fffff, 5'h01, 3'd0, "R6 truncate no overflow");
        vec(64'h47f0000000000000, 2'd1, 32'h7f7fffff, 5'h09, 3'd1, "R6 overflow zero mode");
        vec(64'hc7f0000000000000, 2'd2, 32'hff7fffff, 5'h09, 3'd1, "R6 overflow neg plus mode");
        vec(64'hc7f0000000000000, 2'd3, 32'hff800000, 5'h09, 3'd1, "R6 overflow neg minus mode");

        // R7: underflow flush
        vec(64'h81f0043000040000, 2'd0, 32'h80000000, 5'h05, 3'd1, "R7 R12 underflow neg");
        vec(64'h3800000000000000, 2'd0, 32'h00000000, 5'h05, 3'd1, "R7 exponent zero edge");

        // R8: quiet NaN
        vec(64'h7ff8000000000000, 2'd0, 32'h7fc00000, 5'h00, 3'd0, "R8 quiet nan");
        vec(64'hfffc000020000000, 2'd1, 32'hffe00001, 5'h00, 3'd0, "R8 payload");

        // R9: signaling NaN
        vec(64'h7ff4000000000000, 2'd0, 32'h7fff0000, 5'h10, 3'd1, "R9 R12 signaling");
        vec(64'hfff0000000000001, 2'd3, 32'h7fff0000, 5'h10, 3'd1, "R9 negative signaling");

        // R10: zeros and infinities
        vec(64'h7ff0000000000000, 2'd0, 32'h7f800000, 5'h00, 3'd0, "R10 plus inf");
        vec(64'hfff0000000000000, 2'd2, 32'hff800000, 5'h00, 3'd0, "R10 minus inf");
        vec(64'h0000000000000000, 2'd0, 32'h00000000, 5'h00, 3'd0, "R10 plus zero");
        vec(64'h8000000000000000, 2'd3, 32'h80000000, 5'h00, 3'd0, "R10 minus zero");

        // R11: denormal refused
        vec(64'h0000000000010000, 2'd0, 32'h00000000, 5'h00, 3'd2, "R11 denormal");
        vec(64'h800fffffffffffff, 2'd2, 32'h00000000, 5'h00, 3'd2, "R11 neg denormal");

        // R1: start during a conversion is ignored
        begin
            exp_t e;
            e.res = 32'h3f800000; e.flg = 5'h00; e.tt = 3'd0; e.tag = "R1 busy start ignored";
            @(negedge clk);
            op_in = 64'h3ff0000000000000; rmode = 2'd0; start = 1'b1;
            sb.push_back(e);
            @(negedge clk);
            op_in = 64'h7ff4000000000000; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (!done) @(negedge clk);
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                checks++;
                if (done !== 1'b0) begin
                    fails++;
                    $display("FAIL R1 extra done: actual %b expected 0", done);
                end
            end
        end

        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R1 missing done: actual %0d pending expected 0", sb.size());
        end
        finish_run();
    end
endmodule